// File: doc/BRIEF.md
# PAM4 Transition Census

This block watches a stream of four-level symbol codes (0 to 3) qualified by a valid strobe. It sorts every change of level between two consecutive accepted symbols into one of twelve named start/end pairs, six going up and six going down. It labels each change as even or odd by the position of its ending symbol, so that the two parities of every transition type can be studied apart when the timing of alternate symbols is examined. It also recognises the two fixed run patterns used as rise and fall time markers: a run of zeros followed by a run of threes, and the reverse.

Collection happens inside a window measured in accepted symbols. By default the window is 24573 symbols long, which is three passes of an 8191-symbol quaternary PRBS13 stream. A start pulse opens a new window. Per-type, per-parity counts are read back through a combinational read port. Each classified edge and each marker is also reported as a one-cycle pulse.

Top module: `pam4_edge_census`

## Requirements
- R1: A change from level a to level b is reported with type code 0:0→3, 1:1→2, 2:0→1, 3:2→3, 4:0→2, 5:1→3, 6:3→0, 7:2→1, 8:1→0, 9:3→2, 10:2→0, 11:3→1. No other code appears with a valid edge.
- R2: Cycles with the valid strobe low are ignored. The first accepted symbol of a window has no predecessor and makes no edge. An accepted symbol equal to its predecessor makes no edge and changes no counter.
- R3: Symbols are indexed from 0, starting at the first accepted symbol after a start or reset. An edge is odd when the index of its ending symbol is odd. The counter for type t and parity p is read at address p*16+t, and addresses whose low four bits are 12 to 15 read 0.
- R4: Each counter is CNT_W bits wide and stops at 2^CNT_W-1 instead of wrapping.
- R5: The rise marker pulses when the latest LEAD_LEN+TRAIL_LEN accepted symbols of the current window are LEAD_LEN zeros followed by TRAIL_LEN threes (default 5 and 6).
- R6: The fall marker pulses when those symbols are LEAD_LEN threes followed by TRAIL_LEN zeros.
- R7: Exactly WIN_LEN symbols are accepted per window. The done flag rises in the cycle after the last one and stays high until a start. While done is high, no symbol is accepted and no counter, edge or marker output changes.
- R8: A start pulse clears all counters, the symbol index, the symbol history and the done flag. A symbol presented in the start cycle is dropped.
- R9: The edge pulse, its type and parity, and the marker pulses appear in the cycle after the symbol that causes them, and the counter read reflects that edge from the same cycle.
- R10: After reset, the block is in the same state as after a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Opens a new collection window |
| sym_valid_i | input | 1 | Symbol qualifier |
| sym_i | input | 2 | Symbol level code 0..3 |
| rd_addr_i | input | 5 | Counter address: bit 4 parity, bits 3:0 type |
| rd_data_o | output | CNT_W | Selected counter value |
| done_o | output | 1 | Window complete |
| edge_valid_o | output | 1 | One-cycle edge report |
| edge_type_o | output | 4 | Type code of the reported edge |
| edge_odd_o | output | 1 | Reported edge ends on an odd index |
| rise_mark_o | output | 1 | Rise marker pulse |
| fall_mark_o | output | 1 | Fall marker pulse |

## Verification
A marker can complete on the very symbol that closes the window. In that case the marker pulse and the rising done flag must appear together in one cycle. The bench opens a second window and places a zero-then-three run so that its last three lands at the final index, then expects both in that cycle. It also expects the symbols after that one to leave every output and counter still. A second coincidence is a start pulse arriving together with a valid symbol. The bench judges it by checking that the next accepted symbol is treated as index 0, with no edge.

// File: rtl/pam4_edge_pkg.sv
// Shared types and the transition classification function for the census block.
// Assumes symbol codes 0..3 map to rising amplitude levels.
package pam4_edge_pkg;
    localparam int NUM_EDGE_TYPES = 12;
    localparam int TYPE_W = 4;

    typedef logic [1:0] sym_t;
    typedef logic [TYPE_W-1:0] etype_t;

    // Map a level pair to its type code; equal levels yield the unused code 15.
    function automatic etype_t classify(input sym_t from_lvl, input sym_t to_lvl);
        case ({from_lvl, to_lvl})
            4'b0011: return 4'd0;
            4'b0110: return 4'd1;
            4'b0001: return 4'd2;
            4'b1011: return 4'd3;
            4'b0010: return 4'd4;
            4'b0111: return 4'd5;
            4'b1100: return 4'd6;
            4'b1001: return 4'd7;
            4'b0100: return 4'd8;
            4'b1110: return 4'd9;
            4'b1000: return 4'd10;
            4'b1101: return 4'd11;
            default: return 4'd15;
        endcase
    endfunction
endpackage

// File: rtl/pam4_edge_classifier.sv
// Remembers the last accepted symbol and classifies the change to the next one.
// Assumes accept_i is already qualified by window and start logic.
module pam4_edge_classifier
    import pam4_edge_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear_i,
    input  logic   accept_i,
    input  sym_t   sym_i,
    output logic   hit_o,
    output etype_t type_o
);
    sym_t prev_q;
    logic have_q;

    // Hold the previous symbol of the current window.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            prev_q <= '0;
            have_q <= 1'b0;
        end else if (accept_i) begin
            prev_q <= sym_i;
            have_q <= 1'b1;
        end
    end

    // An edge exists only when a predecessor exists and the level differs.
    always_comb begin
        hit_o  = accept_i && have_q && (prev_q != sym_i);
        type_o = classify(prev_q, sym_i);
    end
endmodule

// File: rtl/pam4_run_marker.sv
// Detects LEAD_LEN equal symbols followed by TRAIL_LEN symbols of the opposite extreme.
// Assumes LEAD_LEN and TRAIL_LEN are at least 1; history restarts on clear.
module pam4_run_marker
    import pam4_edge_pkg::*;
#(
    parameter int LEAD_LEN  = 5,
    parameter int TRAIL_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic accept_i,
    input  sym_t sym_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int DEPTH  = LEAD_LEN + TRAIL_LEN - 1;
    localparam int FILL_W = $clog2(DEPTH + 1);

    sym_t              hist_q [DEPTH];
    logic [FILL_W-1:0] fill_q;
    logic              full, pat_rise, pat_fall;

    // Shift accepted symbols into the history, newest at index 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            fill_q <= '0;
            for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
        end else if (accept_i) begin
            hist_q[0] <= sym_i;
            for (int i = 1; i < DEPTH; i++) hist_q[i] <= hist_q[i-1];
            if (fill_q != FILL_W'(DEPTH)) fill_q <= fill_q + 1'b1;
        end
    end

    // Compare the history against both run shapes.
    always_comb begin
        full     = (fill_q == FILL_W'(DEPTH));
        pat_rise = 1'b1;
        pat_fall = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < TRAIL_LEN - 1) begin
                pat_rise = pat_rise && (hist_q[i] == 2'd3);
                pat_fall = pat_fall && (hist_q[i] == 2'd0);
            end else begin
                pat_rise = pat_rise && (hist_q[i] == 2'd0);
                pat_fall = pat_fall && (hist_q[i] == 2'd3);
            end
        end
        rise_o = accept_i && full && (sym_i == 2'd3) && pat_rise;
        fall_o = accept_i && full && (sym_i == 2'd0) && pat_fall;
    end
endmodule

// File: rtl/pam4_edge_counter_bank.sv
// Saturating counters per edge type and parity, with a combinational read port.
// Assumes type_i < NUM_EDGE_TYPES whenever inc_i is high.
module pam4_edge_counter_bank
    import pam4_edge_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             inc_i,
    input  etype_t           type_i,
    input  logic             odd_i,
    input  logic [4:0]       rd_addr_i,
    output logic [CNT_W-1:0] rd_data_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q [2][NUM_EDGE_TYPES];

    for (genvar p = 0; p < 2; p++) begin : g_par
        for (genvar t = 0; t < NUM_EDGE_TYPES; t++) begin : g_type
            // Count matching edges, holding at the ceiling.
            always_ff @(posedge clk) begin
                if (!rst_n || clear_i)
                    cnt_q[p][t] <= '0;
                else if (inc_i && type_i == TYPE_W'(t) && odd_i == p[0] && cnt_q[p][t] != CNT_MAX)
                    cnt_q[p][t] <= cnt_q[p][t] + 1'b1;
            end
        end
    end

    // Select the addressed counter; unused type slots read zero.
    always_comb begin
        int sel;
        sel = int'(rd_addr_i[3:0]);
        if (sel < NUM_EDGE_TYPES)
            rd_data_o = cnt_q[rd_addr_i[4]][sel];
        else
            rd_data_o = '0;
    end
endmodule

// File: rtl/pam4_edge_census.sv
// Top: gates symbols into a window, classifies edges, flags run markers, counts.
// Assumes start_i is a single-cycle request; it overrides a same-cycle symbol.
module pam4_edge_census
    import pam4_edge_pkg::*;
#(
    parameter int WIN_LEN   = 24573,
    parameter int CNT_W     = 16,
    parameter int LEAD_LEN  = 5,
    parameter int TRAIL_LEN = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             sym_valid_i,
    input  logic [1:0]       sym_i,
    input  logic [4:0]       rd_addr_i,
    output logic [CNT_W-1:0] rd_data_o,
    output logic             done_o,
    output logic             edge_valid_o,
    output logic [3:0]       edge_type_o,
    output logic             edge_odd_o,
    output logic             rise_mark_o,
    output logic             fall_mark_o
);
    localparam int IDX_W = $clog2(WIN_LEN + 1);

    logic [IDX_W-1:0] idx_q;
    logic             done_q;
    logic             accept, hit, rise, fall;
    etype_t           etype;

    assign accept = sym_valid_i && !done_q && !start_i;
    assign done_o = done_q;

    // Track the symbol index and close the window after WIN_LEN symbols.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            idx_q  <= '0;
            done_q <= 1'b0;
        end else if (accept) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_W'(WIN_LEN - 1)) done_q <= 1'b1;
        end
    end

    pam4_edge_classifier u_class (
        .clk(clk), .rst_n(rst_n), .clear_i(start_i), .accept_i(accept),
        .sym_i(sym_i), .hit_o(hit), .type_o(etype)
    );

    pam4_run_marker #(.LEAD_LEN(LEAD_LEN), .TRAIL_LEN(TRAIL_LEN)) u_mark (
        .clk(clk), .rst_n(rst_n), .clear_i(start_i), .accept_i(accept),
        .sym_i(sym_i), .rise_o(rise), .fall_o(fall)
    );

    pam4_edge_counter_bank #(.CNT_W(CNT_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clear_i(start_i), .inc_i(hit),
        .type_i(etype), .odd_i(idx_q[0]), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    // Register the per-symbol reports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_valid_o <= 1'b0;
            edge_type_o  <= '0;
            edge_odd_o   <= 1'b0;
            rise_mark_o  <= 1'b0;
            fall_mark_o  <= 1'b0;
        end else begin
            edge_valid_o <= hit;
            edge_type_o  <= etype;
            edge_odd_o   <= idx_q[0];
            rise_mark_o  <= rise;
            fall_mark_o  <= fall;
        end
    end
endmodule

// File: rtl/pam4_edge_census_checker.sv
// Temporal checks on the census top, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module pam4_edge_census_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       done_o,
    input logic       edge_valid_o,
    input logic [3:0] edge_type_o,
    input logic       rise_mark_o,
    input logic       fall_mark_o
);
    assert_type_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        edge_valid_o |-> (edge_type_o < 4'd12));

    assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    assert_quiet_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (!edge_valid_o && !rise_mark_o && !fall_mark_o));

    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && !edge_valid_o && !rise_mark_o && !fall_mark_o));

    assert_rise_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_mark_o |-> (!edge_valid_o && !fall_mark_o));

    assert_fall_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fall_mark_o |-> !edge_valid_o);
endmodule

bind pam4_edge_census pam4_edge_census_checker u_census_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .edge_valid_o(edge_valid_o), .edge_type_o(edge_type_o),
    .rise_mark_o(rise_mark_o), .fall_mark_o(fall_mark_o)
);

// File: tb/test_pam4_edge_census.sv
// Self-checking bench: small window and narrow counters, arithmetic reference model.
module test_pam4_edge_census;
    localparam int WIN   = 200;
    localparam int CW    = 4;
    localparam int CMAX  = 15;
    localparam int LEAD  = 5;
    localparam int TRAIL = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          sym_valid_i = 1'b0;
    logic [1:0]    sym_i = '0;
    logic [4:0]    rd_addr_i = '0;
    logic [CW-1:0] rd_data_o;
    logic          done_o, edge_valid_o, edge_odd_o, rise_mark_o, fall_mark_o;
    logic [3:0]    edge_type_o;

    pam4_edge_census #(.WIN_LEN(WIN), .CNT_W(CW), .LEAD_LEN(LEAD), .TRAIL_LEN(TRAIL)) i_pam4_edge_census (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sym_valid_i(sym_valid_i),
        .sym_i(sym_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .done_o(done_o),
        .edge_valid_o(edge_valid_o), .edge_type_o(edge_type_o), .edge_odd_o(edge_odd_o),
        .rise_mark_o(rise_mark_o), .fall_mark_o(fall_mark_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Reference model state
    int m_cnt [2][12];
    int m_hist [LEAD+TRAIL];
    int m_fill, m_idx, m_prev;
    bit m_done, m_ev, m_odd, m_rise, m_fall;
    int m_type;
    int lfsr = 32'h1ACE;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_type(input int a, input int b);
        if (a == 0 && b == 3) return 0;
        if (a == 1 && b == 2) return 1;
        if (a == 0 && b == 1) return 2;
        if (a == 2 && b == 3) return 3;
        if (a == 0 && b == 2) return 4;
        if (a == 1 && b == 3) return 5;
        if (a == 3 && b == 0) return 6;
        if (a == 2 && b == 1) return 7;
        if (a == 1 && b == 0) return 8;
        if (a == 3 && b == 2) return 9;
        if (a == 2 && b == 0) return 10;
        return 11;
    endfunction

    function automatic void model_clear();
        for (int p = 0; p < 2; p++) for (int t = 0; t < 12; t++) m_cnt[p][t] = 0;
        m_fill = 0; m_idx = 0; m_prev = 0; m_done = 0;
    endfunction

    function automatic void model_step(input int s, input bit v, input bit st);
        m_ev = 0; m_rise = 0; m_fall = 0;
        if (st) begin
            model_clear();
        end else if (v && !m_done) begin
            m_odd = m_idx[0];
            if (m_idx > 0 && s != m_prev) begin
                m_ev = 1;
                m_type = ref_type(m_prev, s);
                if (m_cnt[m_odd][m_type] < CMAX) m_cnt[m_odd][m_type]++;
            end
            for (int i = LEAD+TRAIL-1; i > 0; i--) m_hist[i] = m_hist[i-1];
            m_hist[0] = s;
            if (m_fill < LEAD+TRAIL) m_fill++;
            if (m_fill == LEAD+TRAIL) begin
                m_rise = 1; m_fall = 1;
                for (int i = 0; i < LEAD+TRAIL; i++) begin
                    if (i < TRAIL) begin
                        m_rise &= (m_hist[i] == 3); m_fall &= (m_hist[i] == 0);
                    end else begin
                        m_rise &= (m_hist[i] == 0); m_fall &= (m_hist[i] == 3);
                    end
                end
            end
            m_prev = s;
            m_idx++;
            if (m_idx == WIN) m_done = 1;
        end
    endfunction

    // Drive one cycle at a negative edge, update the model, check a cycle later.
    task automatic send(input int s, input bit v, input bit st);
        sym_i = 2'(s); sym_valid_i = v; start_i = st;
        @(posedge clk);
        model_step(s, v, st);
        @(negedge clk);
        sym_valid_i = 1'b0; start_i = 1'b0;
        chk(edge_valid_o == m_ev, "R2/R9 edge pulse", int'(edge_valid_o), int'(m_ev));
        if (m_ev) begin
            chk(int'(edge_type_o) == m_type, "R1 edge type", int'(edge_type_o), m_type);
            chk(edge_odd_o == m_odd, "R3 edge parity", int'(edge_odd_o), int'(m_odd));
        end
        chk(rise_mark_o == m_rise, "R5 rise marker", int'(rise_mark_o), int'(m_rise));
        chk(fall_mark_o == m_fall, "R6 fall marker", int'(fall_mark_o), int'(m_fall));
        chk(done_o == m_done, "R7 done flag", int'(done_o), int'(m_done));
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < 32; a++) begin
            int e;
            rd_addr_i = 5'(a);
            #1;
            e = ((a % 16) < 12) ? m_cnt[a/16][a%16] : 0;
            chk(int'(rd_data_o) == e, req, int'(rd_data_o), e);
            @(negedge clk);
        end
    endtask

    function automatic int next_rand();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'h8000_0057 : 0);
        return lfsr & 3;
    endfunction

    task automatic run_len(input int s, input int n);
        for (int i = 0; i < n; i++) send(s, 1, 0);
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(done_o == 1'b0, "R10 done after reset", int'(done_o), 0);
        chk(edge_valid_o == 1'b0, "R10 no edge after reset", int'(edge_valid_o), 0);
        read_all("R10 counters after reset");

        // R1/R2/R3: every ordered pair of levels, with idle gaps and repeats
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                send(a, 1, 0);
                if ((a + b) % 3 == 0) send(b, 0, 0);
                send(b, 1, 0);
            end
        end
        read_all("R1/R3 counters after pair sweep");

        // R5/R6: exact run shapes and a near miss
        run_len(0, LEAD); run_len(3, TRAIL);
        run_len(3, LEAD - TRAIL + 1 > 0 ? LEAD - TRAIL + 1 : 0);
        run_len(0, TRAIL);
        run_len(1, 3); run_len(0, LEAD - 1); run_len(3, TRAIL);

        // R4: drive one type far past the ceiling
        for (int i = 0; i < 40; i++) send((i % 2) * 3, 1, 0);
        read_all("R4 saturated counters");

        // R7: fill the window, then keep driving
        while (m_idx < WIN) send(next_rand(), 1, 0);
        for (int i = 0; i < 10; i++) send(i % 4, 1, 0);
        read_all("R7 counters frozen after window");

        // R8: start coinciding with a valid symbol
        send(2, 1, 1);
        read_all("R8 counters cleared by start");
        send(1, 1, 0);
        chk(edge_valid_o == 1'b0, "R8 first symbol after start has no edge", int'(edge_valid_o), 0);

        // R5 with R7: a rise marker completing on the last index of the window
        while (m_idx < WIN - (LEAD + TRAIL)) send(next_rand(), 1, 0);
        run_len(0, LEAD); run_len(3, TRAIL);
        chk(rise_mark_o == 1'b1 && done_o == 1'b1, "R5/R7 marker with window end",
            int'(rise_mark_o) * 2 + int'(done_o), 3);
        send(0, 1, 0);
        read_all("R7 counters after second window");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule